// File: doc/BRIEF.md
# Single-precision to signed integer converter

This block turns an IEEE 754 single-precision value into a signed 32-bit two's-complement integer. The caller picks one of four rounding modes. A value is presented with a one-cycle valid strobe. Four clock edges later the block raises a one-cycle done pulse together with the integer and an invalid flag. The pipeline accepts a new value on every cycle, so a stream of conversions comes out back to back in issue order.

The first stage examines the biased exponent and the rounding mode. Magnitudes below one, and values that are too large or not numbers, are settled there by plain decode logic. The same stage also prepares the right-shift distance. Values in range then go through three further stages:
- an alignment shift that keeps guard, round and sticky information;
- a mode-dependent increment with a carry-out overflow check;
- a final sign application.

Top module: `fp32_to_int32`

## Requirements
- R1: A biased exponent (bits 30..23) of 158 or more marks the conversion invalid: `out_invalid` is 1 and `out_int` is 0x80000000. This covers infinities, NaNs and exactly -2^31. A carry out of the 31-bit magnitude after rounding gives the same result.
- R2: Mode 00 rounds to nearest with ties to even. The increment is applied when the guard bit is set and the round bit, the sticky bit or the integer LSB is set.
- R3: Mode 01 truncates toward zero.
- R4: Mode 10 rounds toward minus infinity and mode 11 toward plus infinity. An inexact magnitude is incremented only when the sign points in the rounding direction.
- R5: When the biased exponent is below 127 the result is 0 in these cases:
  - mode 01;
  - mode 10 with a positive input;
  - mode 11 with a negative input;
  - mode 00 with an exponent below 126;
  - mode 00 with exponent 126 and a zero fraction.
- R6: When the biased exponent is below 127 and the input is not zero, the result is -1 for a negative input under mode 10. It is +1 for a positive input under mode 11. Under mode 00 with exponent 126 and a nonzero fraction, it is +1 or -1 following the sign.
- R7: Inputs with a biased exponent from 127 to 157 convert to the correctly rounded value of either sign, up to ±(2^31-128), with `out_invalid` 0.
- R8: Positive and negative zero give 0 with `out_invalid` 0 in every mode.
- R9: Denormal inputs follow the below-one rules of R5 and R6.
- R10: `out_done` is a single-cycle pulse exactly four rising edges after the edge that sampled `in_valid`. Inputs issued on consecutive cycles come out on consecutive cycles, in order.
- R11: Reset clears `out_done`, `out_int` and `out_invalid` to 0 and discards conversions still in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_bits` and `in_mode` for one cycle |
| in_bits | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| out_done | output | 1 | One-cycle pulse marking a finished conversion |
| out_int | output | 32 | Signed integer result, held until the next conversion |
| out_invalid | output | 1 | Set with a result that is out of range or not a number |

## Verification
The main path is driven with values whose discarded fraction sits exactly on the half point, just above it, and below it. These values separate ties-to-even from the directed modes, and they show whether the sticky bit reaches the rounding decision. Fractions below one are tried with each sign in each mode, including exponent 126 with and without a fraction. These cases tell the early zero decision apart from the early ±1 decision. The ends of the range are covered by:
- 2^30 and ±(2^31-128), the largest in-range exponent;
- 2^31 and -2^31, the first invalid exponent;
- infinities, NaN, signed zeros and the smallest denormals.

Together these show whether the exponent boundaries and the sign handling sit where they should. All table vectors are issued back to back to expose ordering or latency slips. An isolated issue and a reset during flight check the done pulse.

// File: rtl/fp32_to_int32.sv
module fp32_to_int32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_bits,
  input  logic [1:0]  in_mode,
  output logic        out_done,
  output logic [31:0] out_int,
  output logic        out_invalid
);

  localparam logic [1:0]  M_NEAR = 2'd0;
  localparam logic [1:0]  M_ZERO = 2'd1;
  localparam logic [1:0]  M_DOWN = 2'd2;
  localparam logic [1:0]  M_UP   = 2'd3;
  localparam logic [7:0]  E_HALF = 8'd126;
  localparam logic [7:0]  E_ONE  = 8'd127;
  localparam logic [7:0]  E_BAD  = 8'd158;
  localparam int          MAG_W  = 31;
  localparam int          EXT_W  = MAG_W + 3;
  localparam int          SIG_W  = 24;
  localparam logic [31:0] INT_MIN = 32'h8000_0000;
  localparam logic [EXT_W-1:0] EXT_ONE = {{(EXT_W-1){1'b0}}, 1'b1};

  // stage 0: decode
  logic       d_sgn;
  logic [7:0] d_exp;
  logic [22:0] d_frac;
  logic       d_zero, d_big, d_small, d_one, d_early;
  logic [31:0] d_eval;
  logic [4:0] d_shamt;

  assign d_sgn   = in_bits[31];
  assign d_exp   = in_bits[30:23];
  assign d_frac  = in_bits[22:0];
  assign d_zero  = (in_bits[30:0] == 31'd0);
  assign d_big   = (d_exp >= E_BAD);
  assign d_small = (d_exp < E_ONE);
  assign d_early = d_big | d_small;
  // shift = 157 - exp; only used for exp in 127..157, where low 5 bits suffice
  assign d_shamt = 5'd29 - d_exp[4:0];

  always_comb begin
    d_one = 1'b0;
    if (d_small && !d_zero) begin
      case (in_mode)
        M_DOWN:  d_one = d_sgn;
        M_UP:    d_one = !d_sgn;
        M_NEAR:  d_one = (d_exp == E_HALF) && (d_frac != 23'd0);
        default: d_one = 1'b0;
      endcase
    end
  end

  assign d_eval = d_big ? INT_MIN :
                  d_one ? (d_sgn ? 32'hFFFF_FFFF : 32'd1) : 32'd0;

  // stage 1 registers
  logic             s1_v, s1_sgn, s1_early, s1_einv;
  logic [1:0]       s1_mode;
  logic [31:0]      s1_eval;
  logic [4:0]       s1_sh;
  logic [SIG_W-1:0] s1_sig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_sgn <= 1'b0; s1_early <= 1'b0; s1_einv <= 1'b0;
      s1_mode <= 2'd0; s1_eval <= 32'd0; s1_sh <= 5'd0; s1_sig <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_sgn   <= d_sgn;
        s1_early <= d_early;
        s1_einv  <= d_big;
        s1_mode  <= in_mode;
        s1_eval  <= d_eval;
        s1_sh    <= d_shamt;
        s1_sig   <= {1'b1, d_frac};
      end
    end
  end

  // stage 2: alignment with guard, round, sticky
  logic [EXT_W-1:0] a_ext, a_shift, a_mask;
  logic             a_lost;

  assign a_ext   = {s1_sig, {(EXT_W-SIG_W){1'b0}}};
  assign a_shift = a_ext >> s1_sh;
  assign a_mask  = (EXT_ONE << s1_sh) - EXT_ONE;
  assign a_lost  = |(a_ext & a_mask);

  logic             s2_v, s2_sgn, s2_early, s2_einv, s2_g, s2_r, s2_s;
  logic [1:0]       s2_mode;
  logic [31:0]      s2_eval;
  logic [MAG_W-1:0] s2_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_sgn <= 1'b0; s2_early <= 1'b0; s2_einv <= 1'b0;
      s2_g <= 1'b0; s2_r <= 1'b0; s2_s <= 1'b0;
      s2_mode <= 2'd0; s2_eval <= 32'd0; s2_mag <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_sgn   <= s1_sgn;
        s2_early <= s1_early;
        s2_einv  <= s1_einv;
        s2_mode  <= s1_mode;
        s2_eval  <= s1_eval;
        s2_mag   <= a_shift[EXT_W-1:3];
        s2_g     <= a_shift[2];
        s2_r     <= a_shift[1];
        s2_s     <= a_shift[0] | a_lost;
      end
    end
  end

  // stage 3: rounding increment
  logic        r_inc, r_inexact;
  logic [31:0] r_sum;

  assign r_inexact = s2_g | s2_r | s2_s;

  always_comb begin
    case (s2_mode)
      M_NEAR:  r_inc = s2_g & (s2_r | s2_s | s2_mag[0]);
      M_ZERO:  r_inc = 1'b0;
      M_DOWN:  r_inc = s2_sgn & r_inexact;
      default: r_inc = !s2_sgn & r_inexact;
    endcase
  end

  assign r_sum = {1'b0, s2_mag} + {31'd0, r_inc};

  logic        s3_v, s3_sgn, s3_early, s3_einv;
  logic [31:0] s3_eval, s3_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_v <= 1'b0; s3_sgn <= 1'b0; s3_early <= 1'b0; s3_einv <= 1'b0;
      s3_eval <= 32'd0; s3_sum <= 32'd0;
    end else begin
      s3_v <= s2_v;
      if (s2_v) begin
        s3_sgn   <= s2_sgn;
        s3_early <= s2_early;
        s3_einv  <= s2_einv;
        s3_eval  <= s2_eval;
        s3_sum   <= r_sum;
      end
    end
  end

  // stage 4: second overflow check and sign
  logic        f_ovf;
  logic [31:0] f_val;

  assign f_ovf = s3_sum[MAG_W];
  assign f_val = s3_early ? s3_eval :
                 f_ovf    ? INT_MIN :
                 s3_sgn   ? (~s3_sum + 32'd1) : s3_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done <= 1'b0; out_int <= 32'd0; out_invalid <= 1'b0;
    end else begin
      out_done <= s3_v;
      if (s3_v) begin
        out_int     <= f_val;
        out_invalid <= s3_early ? s3_einv : f_ovf;
      end
    end
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_done);

  // R10
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(in_valid, 4));

  // R1
  invalid_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_int == INT_MIN));

  // R1
  big_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_bits[30:23] >= E_BAD) |-> ##4 out_invalid);

  // R8
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_bits[30:0] == 31'd0) |-> ##4 (out_int == 32'd0 && !out_invalid));

endmodule

// File: tb/test_fp32_to_int32.sv
`timescale 1ns/1ps
module test_fp32_to_int32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = 32'd0;
  logic [1:0]  in_mode = 2'd0;
  logic        out_done;
  logic [31:0] out_int;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fp32_to_int32 i_fp32_to_int32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .in_mode(in_mode), .out_done(out_done), .out_int(out_int),
    .out_invalid(out_invalid)
  );

  // {float bits, mode, expected int, expected invalid, requirement}
  localparam int N = 41;
  localparam logic [74:0] VEC [N] = '{
    {32'h3F800000, 2'd0, 32'h00000001, 1'b0, 8'd2},  // R2 1.0
    {32'h3FC00000, 2'd0, 32'h00000002, 1'b0, 8'd2},  // R2 1.5 tie up to even
    {32'h40200000, 2'd0, 32'h00000002, 1'b0, 8'd2},  // R2 2.5 tie down to even
    {32'hC0200000, 2'd0, 32'hFFFFFFFE, 1'b0, 8'd2},  // R2 -2.5
    {32'h40300000, 2'd0, 32'h00000003, 1'b0, 8'd2},  // R2 2.75
    {32'h40200001, 2'd0, 32'h00000003, 1'b0, 8'd2},  // R2 sticky past half
    {32'h40300000, 2'd1, 32'h00000002, 1'b0, 8'd3},  // R3
    {32'hC0300000, 2'd1, 32'hFFFFFFFE, 1'b0, 8'd3},  // R3
    {32'h40200000, 2'd2, 32'h00000002, 1'b0, 8'd4},  // R4
    {32'hC0200000, 2'd2, 32'hFFFFFFFD, 1'b0, 8'd4},  // R4
    {32'h40200000, 2'd3, 32'h00000003, 1'b0, 8'd4},  // R4
    {32'hC0200000, 2'd3, 32'hFFFFFFFE, 1'b0, 8'd4},  // R4
    {32'h3FA00000, 2'd3, 32'h00000002, 1'b0, 8'd4},  // R4
    {32'h3FC00000, 2'd3, 32'h00000002, 1'b0, 8'd4},  // R4
    {32'hBFC00000, 2'd2, 32'hFFFFFFFE, 1'b0, 8'd4},  // R4
    {32'h3F000000, 2'd0, 32'h00000000, 1'b0, 8'd5},  // R5 0.5
    {32'h3E800000, 2'd0, 32'h00000000, 1'b0, 8'd5},  // R5
    {32'h3F400000, 2'd1, 32'h00000000, 1'b0, 8'd5},  // R5
    {32'h3F400000, 2'd2, 32'h00000000, 1'b0, 8'd5},  // R5
    {32'hBF400000, 2'd3, 32'h00000000, 1'b0, 8'd5},  // R5
    {32'h3F400000, 2'd0, 32'h00000001, 1'b0, 8'd6},  // R6
    {32'hBF400000, 2'd0, 32'hFFFFFFFF, 1'b0, 8'd6},  // R6
    {32'hBE800000, 2'd2, 32'hFFFFFFFF, 1'b0, 8'd6},  // R6
    {32'h3E800000, 2'd3, 32'h00000001, 1'b0, 8'd6},  // R6
    {32'h00000001, 2'd0, 32'h00000000, 1'b0, 8'd9},  // R9
    {32'h80000001, 2'd2, 32'hFFFFFFFF, 1'b0, 8'd9},  // R9
    {32'h00000001, 2'd3, 32'h00000001, 1'b0, 8'd9},  // R9
    {32'h80000001, 2'd1, 32'h00000000, 1'b0, 8'd9},  // R9
    {32'h00000000, 2'd2, 32'h00000000, 1'b0, 8'd8},  // R8
    {32'h80000000, 2'd2, 32'h00000000, 1'b0, 8'd8},  // R8
    {32'h80000000, 2'd3, 32'h00000000, 1'b0, 8'd8},  // R8
    {32'h00000000, 2'd3, 32'h00000000, 1'b0, 8'd8},  // R8
    {32'h4E800000, 2'd0, 32'h40000000, 1'b0, 8'd7},  // R7 2^30
    {32'h4EFFFFFF, 2'd3, 32'h7FFFFF80, 1'b0, 8'd7},  // R7
    {32'hCEFFFFFF, 2'd2, 32'h80000080, 1'b0, 8'd7},  // R7
    {32'h4B000001, 2'd1, 32'h00800001, 1'b0, 8'd7},  // R7
    {32'h4F000000, 2'd0, 32'h80000000, 1'b1, 8'd1},  // R1 2^31
    {32'h7F800000, 2'd1, 32'h80000000, 1'b1, 8'd1},  // R1 +inf
    {32'hFF800000, 2'd2, 32'h80000000, 1'b1, 8'd1},  // R1 -inf
    {32'h7FC00000, 2'd3, 32'h80000000, 1'b1, 8'd1},  // R1 NaN
    {32'hCF000000, 2'd0, 32'h80000000, 1'b1, 8'd1}   // R1 -2^31
  };

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int done_cnt;
    int done_at;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_done == 1'b0 && out_int == 32'd0 && out_invalid == 1'b0, "R11",
          {out_invalid, out_int}, 33'd0);
    rst_n = 1'b1;

    // table streamed back to back (R10 ordering)
    for (int k = 0; k < N + 4; k++) begin
      @(negedge clk);
      if (k >= 4) begin
        logic [74:0] v;
        v = VEC[k-4];
        if (!out_done)
          check(1'b0, "R10", {32'd0, out_done}, 33'd1);
        else
          check(out_int == v[40:9] && out_invalid == v[8],
                $sformatf("R%0d vec%0d", v[7:0], k - 4),
                {out_invalid, out_int}, {v[8], v[40:9]});
      end
      if (k < N) begin
        in_valid = 1'b1;
        in_bits  = VEC[k][74:43];
        in_mode  = VEC[k][42:41];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R10 isolated issue: one pulse, four edges later
    repeat (4) @(negedge clk);
    in_valid = 1'b1; in_bits = 32'hC0600000; in_mode = 2'd0; // -3.5 -> -4
    @(negedge clk);
    in_valid = 1'b0;
    done_cnt = 0; done_at = 0;
    for (int n = 1; n <= 8; n++) begin
      if (out_done) begin
        done_cnt++;
        done_at = n;
        check(out_int == 32'hFFFFFFFC && !out_invalid, "R2",
              {out_invalid, out_int}, {1'b0, 32'hFFFFFFFC});
      end
      if (n < 8) @(negedge clk);
    end
    check(done_cnt == 1, "R10", 33'(done_cnt), 33'd1);
    check(done_at == 4, "R10", 33'(done_at), 33'd4);

    // R11 reset discards in-flight work
    in_valid = 1'b1; in_bits = 32'h7F800000; in_mode = 2'd0;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_int == 32'd0 && !out_invalid && !out_done, "R11",
          {out_invalid, out_int}, 33'd0);
    rst_n = 1'b1;
    done_cnt = 0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (out_done) done_cnt++;
    end
    check(done_cnt == 0, "R11", 33'(done_cnt), 33'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule